// File: doc/BRIEF.md
# Multi-Register Transfer Address Sequencer

This block drives the memory side of a load-multiple or store-multiple operation. A request carries a register-select mask, a base address, the index of the base register and five control bits: pre or post indexing, up or down direction, base write-back, load or store, and user-bank forcing. The sequencer then issues one word access for each selected register. Registers are always visited from the lowest index upward, at addresses that rise by four, whatever the direction. To make that work, the lowest address of the block is worked out before the first access.

The register file and the memory sit outside the block. For stores, the sequencer names a register on `reg_idx` and reads its value back from `reg_rdata`. For loads, and for the base update, it writes through one register write port. The memory side waits on `bus_ready`. Two side-band outputs complete the picture. `user_bank` is a level that asks the register file to use the user-mode bank while the transfer runs. `restore_status` is a one-cycle request to copy the saved status word into the current one.

Top module: `blkx_seq`

## Requirements
- R1: Selected registers are transferred one word access each, in ascending register index, and each accepted access is followed by the next at the previous address plus 4; `bus_rd` (load) and `bus_wr` (store) are never high together.
- R2: The first access address is: base + 4 when up and pre-indexed; base when up and post-indexed; base − 4·N when down and pre-indexed; base − 4·N + 4 when down and post-indexed, where N is the number of selected registers.
- R3: The written-back base value is base + 4·N when up and base − 4·N when down. It is written to the register named by `req_base_idx`, and only when `req_wb` is set.
- R4: An all-zero mask transfers only register 15, with N taken as 16 in every address and write-back computation.
- R5: A store writes the base back in the same cycle that its first access is accepted. A load with write-back writes the base before its first access, so that a loaded value for the base register is written later and wins.
- R6: When register 15 is stored, `bus_wdata` carries its register value plus 4. Every other register is stored unchanged.
- R7: `user_bank` is high through the transfer when forcing is requested for a store, or for a load whose effective mask lacks register 15. Otherwise it stays low, and it is low again in the done cycle.
- R8: `restore_status` is pulsed in the done cycle exactly when a load with forcing has register 15 in its effective mask.
- R9: `done` rises one cycle after the last accepted access for a store, and two cycles after it for a load, which leaves one idle cycle with no access.
- R10: While `bus_ready` is low, the pending access holds its address, register index and strobe.
- R11: After reset no strobe, write or `done` is active. Every request ends with `done` high for exactly one cycle, and no access is made in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a request; sampled only while idle |
| req_list | input | 16 | Register-select mask, bit i selects register i |
| req_base | input | 32 | Base address |
| req_base_idx | input | 4 | Index of the base register |
| req_pre | input | 1 | 1 = pre-indexed, 0 = post-indexed |
| req_up | input | 1 | 1 = addresses rise from the base, 0 = they fall |
| req_wb | input | 1 | Write the updated base back |
| req_load | input | 1 | 1 = load, 0 = store |
| req_user | input | 1 | Force the user register bank / request status restore |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle end-of-request pulse |
| bus_addr | output | 32 | Word address of the current access |
| bus_rd | output | 1 | Read access pending |
| bus_wr | output | 1 | Write access pending |
| bus_wdata | output | 32 | Store data |
| bus_rdata | input | 32 | Load data, valid with bus_ready |
| bus_ready | input | 1 | Access accepted this cycle |
| reg_idx | output | 4 | Register currently being transferred |
| reg_rdata | input | 32 | Register file read data for reg_idx |
| wr_en | output | 1 | Register write strobe |
| wr_idx | output | 4 | Register write index |
| wr_data | output | 32 | Register write data |
| user_bank | output | 1 | Use user-bank registers during this transfer |
| restore_status | output | 1 | Copy saved status into current status |

## Verification
The bench covers all four addressing modes, at unaligned-looking bases and with masks that leave gaps. A design that computed the start address wrongly would put every access of those runs at the wrong place, and the address checks would catch it. For an empty mask, the test expects exactly one access to register 15 together with a base step of 64. A design that saw nothing to do, or that counted one register, would either skip the access or write back the wrong base. Some load runs with write-back include the base register in the mask, and the checks then demand the base write before the loaded one. If the two were swapped, the loaded value would be lost. Other runs cover the +4 on a stored register 15, the user-bank and status-restore combinations, the extra idle cycle that only loads have, and a stalling ready pattern, under which a design that advanced without ready would skip addresses.

// File: rtl/blkx_pkg.sv
package blkx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BASE,
    ST_MOVE,
    ST_TAIL,
    ST_DONE
  } blkx_state_e;
endpackage

// File: rtl/blkx_span.sv
// Works out the effective mask, the lowest address and the write-back
// value of a block so that the transfer itself can always ascend.
module blkx_span #(
  parameter int AW   = 32,
  parameter int NREG = 16
) (
  input  logic [NREG-1:0] list,
  input  logic [AW-1:0]   base,
  input  logic            pre,
  input  logic            up,
  output logic [NREG-1:0] eff_list,
  output logic [AW-1:0]   start_addr,
  output logic [AW-1:0]   wb_addr
);
  localparam int CW = $clog2(NREG + 1);

  logic [CW-1:0] cnt;
  logic [AW-1:0] span;

  always_comb begin
    cnt = '0;
    for (int i = 0; i < NREG; i++) cnt = cnt + CW'(list[i]);
    eff_list = list;
    if (list == '0) begin
      // empty mask: only the top register moves, full-bank stride
      cnt      = CW'(NREG);
      eff_list = NREG'(1) << (NREG - 1);
    end
    span = {{(AW-CW-2){1'b0}}, cnt, 2'b00};
    if (up) start_addr = pre ? base + AW'(4) : base;
    else    start_addr = pre ? base - span : base - span + AW'(4);
    wb_addr = up ? base + span : base - span;
  end
endmodule

// File: rtl/blkx_pick.sv
// Lowest-set-bit picker over the remaining register mask.
module blkx_pick #(
  parameter int NREG = 16
) (
  input  logic [NREG-1:0]         mask,
  output logic [$clog2(NREG)-1:0] idx,
  output logic [NREG-1:0]         rest,
  output logic                    last
);
  localparam int IW = $clog2(NREG);

  always_comb begin
    idx = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (mask[i]) idx = IW'(i);
    end
    rest = mask & (mask - NREG'(1));
    last = (rest == '0);
  end
endmodule

// File: rtl/blkx_seq.sv
module blkx_seq #(
  parameter int AW   = 32,
  parameter int NREG = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  input  logic [NREG-1:0]         req_list,
  input  logic [AW-1:0]           req_base,
  input  logic [$clog2(NREG)-1:0] req_base_idx,
  input  logic                    req_pre,
  input  logic                    req_up,
  input  logic                    req_wb,
  input  logic                    req_load,
  input  logic                    req_user,
  output logic                    busy,
  output logic                    done,
  output logic [AW-1:0]           bus_addr,
  output logic                    bus_rd,
  output logic                    bus_wr,
  output logic [AW-1:0]           bus_wdata,
  input  logic [AW-1:0]           bus_rdata,
  input  logic                    bus_ready,
  output logic [$clog2(NREG)-1:0] reg_idx,
  input  logic [AW-1:0]           reg_rdata,
  output logic                    wr_en,
  output logic [$clog2(NREG)-1:0] wr_idx,
  output logic [AW-1:0]           wr_data,
  output logic                    user_bank,
  output logic                    restore_status
);
  import blkx_pkg::*;

  localparam int IW  = $clog2(NREG);
  localparam logic [IW-1:0] TOP_IDX = IW'(NREG - 1);

  blkx_state_e    state;
  logic [NREG-1:0] rem_mask;
  logic [AW-1:0]   cur_addr;
  logic [AW-1:0]   wb_val;
  logic [IW-1:0]   base_idx;
  logic            is_load;
  logic            do_wb;
  logic            force_usr;
  logic            want_restore;
  logic            first;

  logic [NREG-1:0] span_eff;
  logic [AW-1:0]   span_start;
  logic [AW-1:0]   span_wb;
  logic [IW-1:0]   pick_idx;
  logic [NREG-1:0] pick_rest;
  logic            pick_last;

  blkx_span #(.AW(AW), .NREG(NREG)) u_span (
    .list       (req_list),
    .base       (req_base),
    .pre        (req_pre),
    .up         (req_up),
    .eff_list   (span_eff),
    .start_addr (span_start),
    .wb_addr    (span_wb)
  );

  blkx_pick #(.NREG(NREG)) u_pick (
    .mask (rem_mask),
    .idx  (pick_idx),
    .rest (pick_rest),
    .last (pick_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      rem_mask     <= '0;
      cur_addr     <= '0;
      wb_val       <= '0;
      base_idx     <= '0;
      is_load      <= 1'b0;
      do_wb        <= 1'b0;
      force_usr    <= 1'b0;
      want_restore <= 1'b0;
      first        <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            rem_mask     <= span_eff;
            cur_addr     <= span_start;
            wb_val       <= span_wb;
            base_idx     <= req_base_idx;
            is_load      <= req_load;
            do_wb        <= req_wb;
            force_usr    <= req_user && (!req_load || !span_eff[NREG-1]);
            want_restore <= req_user && req_load && span_eff[NREG-1];
            first        <= 1'b1;
            state        <= (req_load && req_wb) ? ST_BASE : ST_MOVE;
          end
        end
        ST_BASE: state <= ST_MOVE;
        ST_MOVE: begin
          if (bus_ready) begin
            cur_addr <= cur_addr + AW'(4);
            rem_mask <= pick_rest;
            first    <= 1'b0;
            if (pick_last) state <= is_load ? ST_TAIL : ST_DONE;
          end
        end
        ST_TAIL: state <= ST_DONE;
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  logic moving;
  logic base_wr;
  assign moving  = (state == ST_MOVE);
  assign base_wr = (state == ST_BASE) ||
                   (moving && !is_load && do_wb && first && bus_ready);

  assign busy      = (state != ST_IDLE);
  assign done      = (state == ST_DONE);
  assign bus_addr  = cur_addr;
  assign bus_rd    = moving && is_load;
  assign bus_wr    = moving && !is_load;
  assign reg_idx   = pick_idx;
  assign bus_wdata = reg_rdata + ((pick_idx == TOP_IDX) ? AW'(4) : AW'(0));

  assign wr_en   = base_wr || (moving && is_load && bus_ready);
  assign wr_idx  = base_wr ? base_idx : pick_idx;
  assign wr_data = base_wr ? wb_val : bus_rdata;

  assign user_bank      = force_usr &&
                          (state == ST_BASE || state == ST_MOVE || state == ST_TAIL);
  assign restore_status = done && want_restore;
endmodule

// File: rtl/blkx_chk.sv
module blkx_chk #(
  parameter int AW   = 32,
  parameter int NREG = 16
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    bus_rd,
  input logic                    bus_wr,
  input logic                    bus_ready,
  input logic [AW-1:0]           bus_addr,
  input logic [$clog2(NREG)-1:0] reg_idx,
  input logic                    done,
  input logic                    wr_en
);
  logic acc;
  assign acc = bus_rd || bus_wr;

  assert_rw_excl_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot0({bus_rd, bus_wr}));

  assert_addr_step_R1: assert property (@(posedge clk) disable iff (rst)
    (acc && $past(acc) && $past(bus_ready)) |-> bus_addr == $past(bus_addr) + AW'(4));

  assert_idx_rise_R1: assert property (@(posedge clk) disable iff (rst)
    (acc && $past(acc) && $past(bus_ready)) |-> reg_idx > $past(reg_idx));

  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (acc && !bus_ready) |=> (acc && $stable(bus_addr) && $stable(reg_idx)));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    done |-> !(acc || wr_en));
endmodule

bind blkx_seq blkx_chk #(.AW(AW), .NREG(NREG)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_rd    (bus_rd),
  .bus_wr    (bus_wr),
  .bus_ready (bus_ready),
  .bus_addr  (bus_addr),
  .reg_idx   (reg_idx),
  .done      (done),
  .wr_en     (wr_en)
);

// File: tb/test_blkx_seq.sv
module test_blkx_seq;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [15:0] req_list = '0;
  logic [31:0] req_base = '0;
  logic [3:0]  req_base_idx = '0;
  logic        req_pre = 1'b0, req_up = 1'b0, req_wb = 1'b0, req_load = 1'b0, req_user = 1'b0;
  logic        busy, done, bus_rd, bus_wr, wr_en, user_bank, restore_status;
  logic [31:0] bus_addr, bus_wdata, bus_rdata, reg_rdata, wr_data;
  logic [3:0]  reg_idx, wr_idx;
  logic        bus_ready = 1'b1;

  function automatic logic [31:0] mem_f(input logic [31:0] a);
    return a ^ 32'hA5A5_0000;
  endfunction
  function automatic logic [31:0] reg_f(input logic [3:0] i);
    return 32'hC0DE_0000 | {28'd0, i};
  endfunction

  assign bus_rdata = mem_f(bus_addr);
  assign reg_rdata = reg_f(reg_idx);

  blkx_seq i_blkx_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_list(req_list),
    .req_base(req_base), .req_base_idx(req_base_idx), .req_pre(req_pre),
    .req_up(req_up), .req_wb(req_wb), .req_load(req_load), .req_user(req_user),
    .busy(busy), .done(done), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready), .reg_idx(reg_idx), .reg_rdata(reg_rdata),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .user_bank(user_bank), .restore_status(restore_status)
  );

  typedef struct { bit rd; logic [31:0] addr; logic [3:0] idx; logic [31:0] data; bit usr; } acc_t;
  typedef struct { logic [3:0] idx; logic [31:0] data; } wr_t;
  acc_t acc_q[$];
  wr_t  wr_q[$];
  acc_t me;
  wr_t  mw;

  int total = 0, bad = 0, cyc = 0, last_acc = 0;
  bit stall = 1'b0;
  string cur_tag = "R11";

  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge clk) begin
    #1;
    bus_ready = !stall || ((cyc % 3) != 0);
  end

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", cur_tag, what, act, exp);
    end
  endtask

  // monitor: pops expected items as the design produces them
  always @(negedge clk) begin
    if (!rst) begin
      if ((bus_rd || bus_wr) && bus_ready) begin
        if (acc_q.size() == 0) chk(1'b0, "R1 unexpected access", bus_addr, 32'h0);
        else begin
          me = acc_q.pop_front();
          chk(bus_rd == me.rd, "R1 access direction", {31'd0, bus_rd}, {31'd0, me.rd});
          chk(bus_addr == me.addr, "R1/R2 access address", bus_addr, me.addr);
          chk(reg_idx == me.idx, "R1 register order", {28'd0, reg_idx}, {28'd0, me.idx});
          if (!me.rd) chk(bus_wdata == me.data, "R6 store data", bus_wdata, me.data);
          chk(user_bank == me.usr, "R7 user bank", {31'd0, user_bank}, {31'd0, me.usr});
        end
        last_acc = cyc;
      end
      if (wr_en) begin
        if (wr_q.size() == 0) chk(1'b0, "R5 unexpected register write", {28'd0, wr_idx}, 32'h0);
        else begin
          mw = wr_q.pop_front();
          chk(wr_idx == mw.idx, "R3/R5 write index", {28'd0, wr_idx}, {28'd0, mw.idx});
          chk(wr_data == mw.data, "R3/R5 write data", wr_data, mw.data);
        end
      end
    end
  end

  // driver: pushes the expected items, then issues the request
  task automatic run(input logic [15:0] lst, input logic [31:0] base, input bit pre, input bit up,
                     input bit wb, input bit ld, input bit usr, input logic [3:0] bidx, input string tag);
    logic [15:0] eff;
    int n, waited;
    logic [31:0] st, wbv, a;
    bit force_u, first;
    acc_t e;
    wr_t w;
    cur_tag = tag;
    eff = (lst == 16'h0) ? 16'h8000 : lst;
    n   = (lst == 16'h0) ? 16 : $countones(lst);
    st  = up ? (pre ? base + 32'd4 : base) : (base - 32'(4 * n) + (pre ? 32'd0 : 32'd4));
    wbv = up ? base + 32'(4 * n) : base - 32'(4 * n);
    force_u = usr && (!ld || !eff[15]);
    if (ld && wb) begin w.idx = bidx; w.data = wbv; wr_q.push_back(w); end
    a = st;
    first = 1'b1;
    for (int i = 0; i < 16; i++) begin
      if (eff[i]) begin
        e.rd = ld; e.addr = a; e.idx = 4'(i);
        e.data = reg_f(4'(i)) + ((i == 15) ? 32'd4 : 32'd0);
        e.usr = force_u;
        acc_q.push_back(e);
        if (ld) begin w.idx = 4'(i); w.data = mem_f(a); wr_q.push_back(w); end
        else if (wb && first) begin w.idx = bidx; w.data = wbv; wr_q.push_back(w); end
        first = 1'b0;
        a = a + 32'd4;
      end
    end
    @(negedge clk);
    req_list = lst; req_base = base; req_base_idx = bidx; req_pre = pre; req_up = up;
    req_wb = wb; req_load = ld; req_user = usr; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    waited = 0;
    while (!done && waited < 500) begin
      @(negedge clk);
      waited++;
    end
    if (!done) begin
      chk(1'b0, "R11 done never arrived", 32'(waited), 32'd0);
      acc_q.delete();
      wr_q.delete();
    end else begin
      chk(restore_status == (ld && usr && eff[15]), "R8 status restore",
          {31'd0, restore_status}, {31'd0, ld && usr && eff[15]});
      chk((cyc - last_acc) == (ld ? 2 : 1), "R9 done after last access",
          32'(cyc - last_acc), ld ? 32'd2 : 32'd1);
      chk(!user_bank, "R7 bank released at done", {31'd0, user_bank}, 32'd0);
      chk(acc_q.size() == 0 && wr_q.size() == 0, "R11 all items seen",
          32'(acc_q.size() + wr_q.size()), 32'd0);
      @(negedge clk);
      chk(!done, "R11 done single pulse", {31'd0, done}, 32'd0);
    end
  endtask

  initial begin
    #1_000_000;
    bad++;
    $display("FAIL R11 watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !bus_rd && !bus_wr && !wr_en && !restore_status, "R11 reset state",
        {26'd0, busy, done, bus_rd, bus_wr, wr_en, restore_status}, 32'd0);

    run(16'h0006, 32'h0000_3000, 0, 1, 1, 1, 0, 4'd0, "R1 R3 R5 load up-post wb");
    run(16'h0006, 32'h0000_3000, 0, 1, 1, 0, 0, 4'd0, "R1 R3 R5 store up-post wb");
    run(16'h00F0, 32'h0000_4000, 1, 0, 1, 1, 0, 4'd1, "R2 R3 load down-pre");
    run(16'h8011, 32'h0000_5010, 0, 0, 1, 0, 0, 4'd2, "R2 R6 store down-post");
    run(16'h1234, 32'h0000_6000, 1, 1, 1, 1, 0, 4'd4, "R2 R5 load up-pre base in list");
    run(16'h0000, 32'h0000_4000, 0, 1, 1, 1, 0, 4'd0, "R4 empty list load");
    run(16'h0000, 32'h0000_4100, 1, 0, 1, 0, 0, 4'd3, "R4 R6 empty list store");
    run(16'h0C03, 32'h0000_7000, 0, 1, 0, 0, 1, 4'd5, "R7 forced store");
    run(16'h0300, 32'h0000_7100, 1, 1, 0, 1, 1, 4'd5, "R7 forced load no r15");
    run(16'h8002, 32'h0000_7200, 0, 1, 0, 1, 1, 4'd0, "R8 forced load with r15");
    run(16'hFFFF, 32'h0000_8000, 0, 0, 1, 1, 0, 4'd6, "R2 R9 full list load down-post");
    stall = 1'b1;
    run(16'h00A5, 32'h0000_9000, 1, 0, 1, 0, 0, 4'd8, "R10 stalled store down-pre");
    run(16'h5001, 32'h0000_9100, 0, 1, 1, 1, 1, 4'd12, "R10 stalled load up-post");
    run(16'h0000, 32'h0000_9200, 0, 0, 1, 1, 1, 4'd1, "R10 R4 R8 stalled empty load");
    stall = 1'b0;
    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule